// File: doc/BRIEF.md
# Colour Lookup Table Load Port

This block holds a 256-entry colour lookup table, each entry made of 8-bit red, green and blue parts, and lets software fill it through a small 32-bit register window. The window has two live word addresses. The entry pointer sits at byte offset 0. A shared colour data port sits at byte offset 4.

Software first writes the pointer. It then pushes colour parts through the data port three at a time, in the order red, green, blue. After every blue part the pointer steps to the next entry on its own, so a whole table loads as one pointer write followed by a stream of data writes. Both the pointer and the colour values travel in the most significant byte of the bus word.

A separate, purely combinational lookup port lets the pixel path read any entry by its 8-bit number. Register reads always return zero.

Top module: `clut_loader`

## Requirements
- R1: A write of all four byte lanes to byte offset 0 sets the entry pointer to write-data bits 31:24 and returns the part sequencer to the red step.
- R2: Full-word writes to byte offset 4 store write-data bits 31:24 into the pointed entry. The first write goes to red, the second to green and the third to blue.
- R3: The cycle after a blue part is stored, the pointer holds its old value plus one modulo 256, so entry 255 is followed by entry 0. The sequencer is then back at the red step.
- R4: `reg_rdata` is zero at all times, for reads and writes alike.
- R5: After reset, every entry reads as 0x000000 except entry 255, which reads as 0xFFFFFF. The pointer is 0 and the sequencer is at the red step.
- R6: Writes to byte offsets 8 and 12, and to any byte address whose two low bits are not zero, change neither the table, the pointer nor the sequencer.
- R7: Writes whose byte-lane enables are not all ones change neither the table, the pointer nor the sequencer.
- R8: `pix_rgb` gives entry `pix_idx` in the same cycle as {red[23:16], green[15:8], blue[7:0]}. When a write lands on that entry in that cycle, the output still shows the value from before the write.
- R9: A pointer write in the middle of a triplet keeps the parts already stored, and the next data write goes to the red part of the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Access strobe for the register window |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 4 | Byte address inside the 16-byte window |
| reg_be | input | 4 | Byte-lane enables; only 4'hF writes are accepted |
| reg_wdata | input | 32 | Write data; only bits 31:24 are used |
| reg_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Lookup entry number |
| pix_rgb | output | 24 | Lookup result {red, green, blue} |

## Verification
A write accepted at one rising edge is visible on `pix_rgb` shortly after that edge. The old value therefore has to hold while the write is still being presented. The bench drives each access just after a falling edge and compares the lookup against its model of the table before the rising edge, which covers the same-cycle old-value rule. It then updates the model at the rising edge and compares again at the next falling edge, which covers the one-edge update. The pointer and sequencer are observed only through the entry that later data writes reach. `reg_rdata` is compared at both sample points of every cycle.

// File: rtl/clut_loader.sv
module clut_loader #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_sel,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W/8-1:0] reg_be,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [IDX_W-1:0]    pix_idx,
  output logic [3*COMP_W-1:0] pix_rgb
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [ADDR_W-1:0] PTR_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] DAT_OFS = ADDR_W'(4);

  typedef enum logic [1:0] {STEP_R, STEP_G, STEP_B, STEP_X} step_t;

  logic [COMP_W-1:0] red_q [ENTRIES];
  logic [COMP_W-1:0] grn_q [ENTRIES];
  logic [COMP_W-1:0] blu_q [ENTRIES];
  logic [IDX_W-1:0]  ptr_q;
  step_t             step_q;

  wire full_wr  = reg_sel && reg_we && (reg_be == '1);
  wire ptr_wr   = full_wr && (reg_addr == PTR_OFS);
  wire dat_wr   = full_wr && (reg_addr == DAT_OFS);
  wire [COMP_W-1:0] wr_byte = reg_wdata[DATA_W-1 -: COMP_W];
  wire [IDX_W-1:0]  wr_ptr  = reg_wdata[DATA_W-1 -: IDX_W];
  wire unused_low = ^reg_wdata[DATA_W-COMP_W-1:0];

  assign reg_rdata = '0;
  assign pix_rgb   = {red_q[pix_idx], grn_q[pix_idx], blu_q[pix_idx]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      step_q <= STEP_R;
    end else if (ptr_wr) begin
      ptr_q  <= wr_ptr;
      step_q <= STEP_R;
    end else if (dat_wr) begin
      case (step_q)
        STEP_R:  step_q <= STEP_G;
        STEP_G:  step_q <= STEP_B;
        STEP_B: begin
          step_q <= STEP_R;
          ptr_q  <= ptr_q + 1'b1;
        end
        default: step_q <= STEP_R;
      endcase
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [COMP_W-1:0] RST_V = (e == ENTRIES - 1) ? '1 : '0;
    wire hit = dat_wr && (ptr_q == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        red_q[e] <= RST_V;
        grn_q[e] <= RST_V;
        blu_q[e] <= RST_V;
      end else if (hit) begin
        case (step_q)
          STEP_R:  red_q[e] <= wr_byte;
          STEP_G:  grn_q[e] <= wr_byte;
          STEP_B:  blu_q[e] <= wr_byte;
          default: ;
        endcase
      end
    end
  end

  // R1
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (ptr_q == $past(wr_ptr)) && (step_q == STEP_R));

  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !ptr_wr && step_q == STEP_R) |=> step_q == STEP_G);

  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && step_q == STEP_B) |=> (ptr_q == $past(ptr_q) + 1'b1) && (step_q == STEP_R));

  // R6
  bad_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_wr && reg_addr != PTR_OFS && reg_addr != DAT_OFS) |=> $stable(ptr_q) && $stable(step_q));

  // R7
  part_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_we && reg_be != '1) |=> $stable(ptr_q) && $stable(step_q));

  // R2
  step_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_q != STEP_X);
endmodule

// File: tb/clut_loader_bench.sv
module clut_loader_bench;
  logic clk = 0, rst_n = 0;
  logic reg_sel = 0, reg_we = 0;
  logic [3:0] reg_addr = 0, reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0] pix_idx = 0;
  logic [23:0] pix_rgb;
  int checks = 0, fails = 0;
  bit done = 0;
  int mr[256], mg[256], mb[256];
  int mptr = 0, mstep = 0;

  always #5 clk = ~clk;

  clut_loader u_clut_loader (.clk, .rst_n, .reg_sel, .reg_we, .reg_addr, .reg_be,
    .reg_wdata, .reg_rdata, .pix_idx, .pix_rgb);

  function automatic logic [23:0] exp_rgb(int i);
    return {mr[i][7:0], mg[i][7:0], mb[i][7:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(bit s, bit w, logic [3:0] a, logic [3:0] be, logic [31:0] d);
    int v = d[31:24];
    if (!(s && w && be == 4'hF)) return;
    if (a == 4'h0) begin
      mptr = v; mstep = 0;
    end else if (a == 4'h4) begin
      if (mstep == 0) begin mr[mptr] = v; mstep = 1; end
      else if (mstep == 1) begin mg[mptr] = v; mstep = 2; end
      else begin mb[mptr] = v; mstep = 0; mptr = (mptr + 1) % 256; end
    end
  endtask

  // one bus cycle: drive after falling edge, check old value (R8), edge, check new (R2)
  task automatic cyc(bit s, bit w, logic [3:0] a, logic [3:0] be, logic [31:0] d, logic [7:0] li,
                     string req);
    reg_sel = s; reg_we = w; reg_addr = a; reg_be = be; reg_wdata = d; pix_idx = li;
    #1;
    chk("R8 same-cycle old value", {8'h0, pix_rgb}, {8'h0, exp_rgb(li)});
    chk("R4 rdata zero", reg_rdata, 32'h0);
    @(posedge clk);
    model_edge(s, w, a, be, d);
    @(negedge clk);
    chk(req, {8'h0, pix_rgb}, {8'h0, exp_rgb(li)});
    chk("R4 rdata zero", reg_rdata, 32'h0);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] v, logic [7:0] li, string req);
    cyc(1, 1, a, 4'hF, {v, 24'h5A5A5A}, li, req);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mr[i] = (i == 255) ? 255 : 0; mg[i] = mr[i]; mb[i] = mr[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R5 reset contents
    for (int i = 0; i < 256; i++) cyc(0, 0, 0, 0, 0, 8'(i), "R5 reset contents");
    // R5 pointer 0 and red step after reset
    wr(4, 8'h11, 0, "R5 reset pointer red");
    wr(4, 8'h22, 0, "R5 reset pointer green");
    wr(4, 8'h33, 0, "R5 reset pointer blue");
    wr(4, 8'h44, 1, "R3 auto step to entry 1");
    // R1 pointer load, R2 triplet order
    wr(0, 8'd10, 10, "R1 pointer load");
    wr(4, 8'hA1, 10, "R2 red");
    wr(4, 8'hB2, 10, "R2 green");
    wr(4, 8'hC3, 10, "R2 blue");
    wr(4, 8'hD4, 11, "R3 next entry red");
    // R1 pointer write clears partial step
    wr(0, 8'd255, 255, "R1 load 255");
    wr(4, 8'h01, 255, "R2 red 255");
    wr(4, 8'h02, 255, "R2 green 255");
    wr(4, 8'h03, 255, "R2 blue 255");
    wr(4, 8'h77, 0, "R3 wrap to entry 0");
    // R9 mid-triplet pointer write
    wr(0, 8'd20, 20, "R1 load 20");
    wr(4, 8'h55, 20, "R9 red 20");
    wr(4, 8'h66, 20, "R9 green 20");
    wr(0, 8'd21, 20, "R9 partial kept");
    wr(4, 8'h99, 21, "R9 new entry red");
    // R6 ignored offsets and misaligned addresses
    wr(8, 8'hEE, 21, "R6 offset 8 ignored");
    wr(12, 8'hEE, 21, "R6 offset 12 ignored");
    wr(5, 8'hEE, 21, "R6 misaligned ignored");
    wr(1, 8'd3, 21, "R6 misaligned ptr ignored");
    wr(4, 8'h12, 21, "R6 green still next");
    // R7 partial byte enables
    cyc(1, 1, 4, 4'h8, 32'hEE000000, 21, "R7 partial data ignored");
    cyc(1, 1, 0, 4'h7, 32'h03000000, 21, "R7 partial ptr ignored");
    wr(4, 8'h34, 21, "R7 blue still next");
    wr(4, 8'h56, 22, "R7 pointer advanced");
    // R4 reads have no effect
    cyc(1, 0, 0, 4'hF, 32'h05000000, 22, "R4 read no effect");
    cyc(1, 0, 4, 4'hF, 32'h05000000, 22, "R4 read no effect");
    // R8 lookup of the entry being written
    wr(0, 8'd40, 40, "R1 load 40");
    wr(4, 8'hF0, 40, "R8 red new after edge");
    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      int r = $urandom_range(0, 9);
      logic [3:0] a = (r < 6) ? 4'h4 : (r < 8) ? 4'h0 : 4'($urandom_range(0, 15));
      logic [3:0] be = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      cyc(1, ($urandom_range(0, 4) != 0), a, be, $urandom, 8'($urandom), "R2 mixed traffic");
    end
    for (int i = 0; i < 256; i++) cyc(0, 0, 0, 0, 0, 8'(i), "R2 final table");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule